// File: doc/BRIEF.md
# Glitch-Free Selectable Card Clock Divider

This block turns a fast reference clock into a card clock. The card clock runs at the reference rate divided by 8, 4 or 2, or it is the reference clock passed through unchanged. A two-bit select chooses the ratio. The select may be changed at any time while the clock runs, and its two bits may change at different moments. The block resynchronises the select into the reference domain. It then waits until the new code has been steady for a fixed number of reference cycles.

A new ratio is applied only where the current low phase of the output ends. The last old pulse and the first new pulse both keep their full widths, so no runt high or low phase reaches the card. After reset the output is low, and the ratio comes from the select value present when reset is released.

Top module: `ckdiv_top`

## Requirements
- R1: The select encoding is 00 = divide by 8, 01 = divide by 4, 11 = divide by 2 and 10 = pass-through. In steady state, divide by N gives high and low phases of N/2 reference periods each. In pass-through, the output follows the reference clock.
- R2: Each select bit passes through two reference-clock flop stages before use, so the select may change at any time relative to the reference clock. A changed code is eventually adopted.
- R3: A new code is adopted only after it has stayed unchanged for 8 consecutive reference cycles at the synchroniser output. The output never shows the new ratio earlier than 8 reference periods after the select change.
- R4: An intermediate code held for fewer than 8 reference cycles, such as one seen while the two bits change at different times, is ignored. No phase of that code's width appears.
- R5: A ratio change is applied only at the end of a complete low phase. Every phase around the switch has the exact width of the old ratio or of the new ratio. The single exception is entering pass-through, where the final divided low phase is longer by exactly one reference period.
- R6: During any switch, no high or low phase of the output is shorter than 45% of the reference period.
- R7: While reset is asserted, the output is low. After release, the ratio given by the select is used at once, without the settling wait. The first high phase starts within one and a half reference periods.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| refClk | input | 1 | Fast reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| divSel | input | 2 | Ratio select, may be asynchronous to refClk |
| cardClk | output | 1 | Divided card clock |

## Verification
The hardest situation to reach from the ports is a ratio change where the two select bits move at different times. The short intermediate code must be rejected while the switch still lands cleanly on a phase boundary. The bench creates this by stepping one bit and then holding the second bit back for fewer cycles than the settling window, at several offsets from the reference edge. It runs this for every ordered pair of ratios. It timestamps every output edge and compares each phase against the old width, the new width and the pass-through exception.

// File: rtl/ckdiv_pkg.sv
`timescale 1ns/1ps
package ckdiv_pkg;

  localparam int HALF_W = 3;

  // Ratio codes; the encoding is visible at the select pins.
  typedef enum logic [1:0] {
    RATIO_8 = 2'b00,
    RATIO_4 = 2'b01,
    RATIO_2 = 2'b11,
    RATIO_1 = 2'b10
  } ratio_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic   apply;
    ratio_e ratio;
  } ctrlStrobe_t;

  // Number of reference cycles in one phase; zero means pass-through.
  function automatic logic [HALF_W-1:0] halfLen(ratio_e r);
    case (r)
      RATIO_8: halfLen = HALF_W'(4);
      RATIO_4: halfLen = HALF_W'(2);
      RATIO_2: halfLen = HALF_W'(1);
      default: halfLen = HALF_W'(0);
    endcase
  endfunction

endpackage

// File: rtl/ckdiv_sync.sv
`timescale 1ns/1ps
module ckdiv_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) chain[0] <= din;

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) chain[s] <= chain[s-1];
    end
  endgenerate

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/ckdiv_ctrl.sv
`timescale 1ns/1ps
module ckdiv_ctrl
  import ckdiv_pkg::*;
#(
  parameter int SETTLE_CYCLES = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  syncSel,
  input  ratio_e      curRatio,
  input  logic        atBoundary,
  output ctrlStrobe_t strobe,
  output ratio_e      acceptSel
);

  localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_CYCLES - 1);

  ratio_e            candSel;
  ratio_e            selNow;
  logic [CNT_W-1:0]  settleCnt;
  logic              armed;

  assign selNow = ratio_e'(syncSel);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed     <= 1'b0;
      candSel   <= RATIO_8;
      acceptSel <= RATIO_8;
      settleCnt <= '0;
    end else if (!armed) begin
      // First cycle after reset: take the select as it stands.
      armed     <= 1'b1;
      candSel   <= selNow;
      acceptSel <= selNow;
      settleCnt <= '0;
    end else if (selNow != candSel) begin
      candSel   <= selNow;
      settleCnt <= '0;
    end else if (settleCnt == LAST) begin
      acceptSel <= candSel;
    end else begin
      settleCnt <= settleCnt + 1'b1;
    end
  end

  always_comb begin
    strobe.apply = !armed || (atBoundary && (acceptSel != curRatio));
    strobe.ratio = armed ? acceptSel : selNow;
  end

endmodule

// File: rtl/ckdiv_dpath.sv
`timescale 1ns/1ps
module ckdiv_dpath
  import ckdiv_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  ctrlStrobe_t strobe,
  output logic        cardClk,
  output logic        divQ,
  output logic        reqPass,
  output ratio_e      curRatio,
  output logic        atBoundary
);

  logic [HALF_W-1:0] phaseCnt;
  logic [HALF_W-1:0] phaseLast;
  logic              passEn;

  assign phaseLast  = halfLen(curRatio) - HALF_W'(1);
  assign atBoundary = reqPass || (!divQ && (phaseCnt == phaseLast));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curRatio <= RATIO_8;
      phaseCnt <= '0;
      divQ     <= 1'b0;
      reqPass  <= 1'b0;
    end else if (strobe.apply) begin
      curRatio <= strobe.ratio;
      phaseCnt <= '0;
      if (strobe.ratio == RATIO_1) begin
        reqPass <= 1'b1;
        divQ    <= 1'b0;
      end else begin
        reqPass <= 1'b0;
        divQ    <= 1'b1;
      end
    end else if (!reqPass) begin
      if (phaseCnt == phaseLast) begin
        divQ     <= ~divQ;
        phaseCnt <= '0;
      end else begin
        phaseCnt <= phaseCnt + 1'b1;
      end
    end
  end

  // Pass-through enable only moves while the reference clock is low.
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) passEn <= 1'b0;
    else       passEn <= reqPass;
  end

  assign cardClk = (clk & passEn) | divQ;

endmodule

// File: rtl/ckdiv_top.sv
`timescale 1ns/1ps
module ckdiv_top
  import ckdiv_pkg::*;
#(
  parameter int SYNC_STAGES   = 2,
  parameter int SETTLE_CYCLES = 8
) (
  input  logic       refClk,
  input  logic       rstN,
  input  logic [1:0] divSel,
  output logic       cardClk
);

  logic [1:0]  syncSel;
  ctrlStrobe_t strobe;
  ratio_e      curRatio;
  ratio_e      acceptSel;
  logic        atBoundary;
  logic        divQ;
  logic        reqPass;

  ckdiv_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (refClk),
    .din  (divSel),
    .dout (syncSel)
  );

  ckdiv_ctrl #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_ctrl (
    .clk        (refClk),
    .rstN       (rstN),
    .syncSel    (syncSel),
    .curRatio   (curRatio),
    .atBoundary (atBoundary),
    .strobe     (strobe),
    .acceptSel  (acceptSel)
  );

  ckdiv_dpath u_dpath (
    .clk        (refClk),
    .rstN       (rstN),
    .strobe     (strobe),
    .cardClk    (cardClk),
    .divQ       (divQ),
    .reqPass    (reqPass),
    .curRatio   (curRatio),
    .atBoundary (atBoundary)
  );

endmodule

// File: rtl/ckdiv_checker.sv
`timescale 1ns/1ps
module ckdiv_checker #(
  parameter int SETTLE_CYCLES = 8
) (
  input logic       refClk,
  input logic       rstN,
  input logic       cardClk,
  input logic       divQ,
  input logic       reqPass,
  input logic [1:0] curRatio,
  input logic [1:0] acceptSel,
  input logic [1:0] syncSel
);

  localparam int RUN_W = $clog2(SETTLE_CYCLES + 2) + 1;

  function automatic logic [3:0] halfOf(logic [1:0] code);
    case (code)
      2'b00:   halfOf = 4'd4;
      2'b01:   halfOf = 4'd2;
      2'b11:   halfOf = 4'd1;
      default: halfOf = 4'd0;
    endcase
  endfunction

  logic [3:0]       hiRun;
  logic [RUN_W-1:0] sameRun;
  logic [1:0]       prevSync;
  logic [1:0]       sinceRst;

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      hiRun    <= '0;
      sameRun  <= '0;
      prevSync <= '0;
      sinceRst <= '0;
    end else begin
      hiRun    <= !divQ ? 4'd0 : ((hiRun == 4'hF) ? hiRun : hiRun + 4'd1);
      prevSync <= syncSel;
      if (syncSel != prevSync)        sameRun <= '0;
      else if (sameRun != '1)         sameRun <= sameRun + 1'b1;
      if (sinceRst != 2'd3)           sinceRst <= sinceRst + 2'd1;
    end
  end

  always @(negedge refClk) begin
    if (!rstN) AST_RESET_LOW: assert (!cardClk); // R7
  end

  AST_HIGH_WIDTH: assert property (@(posedge refClk) disable iff (!rstN)
    (!divQ && $past(divQ)) |-> (hiRun == halfOf(curRatio))); // R1

  AST_SWITCH_AT_LOW: assert property (@(posedge refClk) disable iff (!rstN)
    (curRatio != $past(curRatio)) |-> !$past(divQ)); // R5

  AST_PASS_EXCL: assert property (@(posedge refClk) disable iff (!rstN)
    reqPass |-> !divQ); // R1

  AST_SETTLED: assert property (@(posedge refClk) disable iff (!rstN)
    ((sinceRst == 2'd3) && (acceptSel != $past(acceptSel)))
      |-> (sameRun >= RUN_W'(SETTLE_CYCLES))); // R3

endmodule

bind ckdiv_top ckdiv_checker #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_chk (
  .refClk    (refClk),
  .rstN      (rstN),
  .cardClk   (cardClk),
  .divQ      (divQ),
  .reqPass   (reqPass),
  .curRatio  (curRatio),
  .acceptSel (acceptSel),
  .syncSel   (syncSel)
);

// File: tb/tb_ckdiv_top.sv
`timescale 1ns/1ps
module tb_ckdiv_top;

  logic       refClk = 1'b0;
  logic       rstN   = 1'b1;
  logic [1:0] divSel = 2'b00;
  logic       cardClk;

  int     checks = 0;
  int     errors = 0;
  int     narrowCnt = 0;
  bit     monOn = 1'b0;
  longint lastEdge = 0;

  always #4 refClk = ~refClk; // 125 MHz

  ckdiv_top dut (
    .refClk  (refClk),
    .rstN    (rstN),
    .divSel  (divSel),
    .cardClk (cardClk)
  );

  // Phase-width watch: 45% of the 8 ns reference period.
  always @(cardClk) begin
    if (monOn && (($time - lastEdge) * 100 < 45 * 8)) narrowCnt++;
    lastEdge = $time;
  end

  function automatic longint halfNs(logic [1:0] code);
    case (code)
      2'b00:   return 32;
      2'b01:   return 16;
      2'b11:   return 8;
      default: return 4;
    endcase
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic waitCycles(int n);
    repeat (n) @(posedge refClk);
    #2;
  endtask

  task automatic setSel(logic [1:0] v);
    if (v[0] != divSel[0] && v[1] != divSel[1]) begin
      divSel[0] = v[0];
      @(posedge refClk);
      #2;
    end
    divSel = v;
  endtask

  task automatic measureHL(output longint hi, output longint lo);
    longint t0;
    @(posedge cardClk); t0 = $time;
    @(negedge cardClk); hi = $time - t0; t0 = $time;
    @(posedge cardClk); lo = $time - t0;
  endtask

  task automatic testReset();
    longint tRel, hi, lo;
    divSel = 2'b01;
    #1 rstN = 1'b0;
    for (int i = 0; i < 3; i++) begin
      waitCycles(2);
      check(cardClk == 1'b0, "R7", "output low in reset", cardClk, 0);
    end
    @(negedge refClk);
    rstN = 1'b1;
    tRel = $time;
    lastEdge = $time;
    monOn = 1'b1;
    @(posedge cardClk);
    check(($time - tRel) <= 12, "R7", "first rise after release", $time - tRel, 12);
    @(negedge cardClk);
    hi = $time - tRel - 4;
    check(hi == 16, "R7", "first high width", hi, 16);
    measureHL(hi, lo);
    check(lo == 16, "R7", "low width after release", lo, 16);
  endtask

  task automatic testSteady(logic [1:0] code);
    longint hi, lo;
    setSel(code);
    waitCycles(40);
    measureHL(hi, lo);
    check(hi == halfNs(code), "R1", $sformatf("high width code %b", code), hi, halfNs(code));
    check(lo == halfNs(code), "R1", $sformatf("low width code %b", code), lo, halfNs(code));
  endtask

  task automatic testSettle();
    longint tChg, lastE, startNew;
    setSel(2'b11);
    waitCycles(40);
    @(negedge refClk);
    divSel = 2'b01;
    tChg = $time;
    startNew = -1;
    @(cardClk); lastE = $time;
    for (int i = 0; i < 200 && startNew < 0; i++) begin
      @(cardClk);
      if ($time - lastE == 16) startNew = lastE;
      lastE = $time;
    end
    check(startNew - tChg >= 64, "R3", "new ratio not before settle", startNew - tChg, 64);
    check(startNew >= 0 && startNew - tChg <= 200, "R2", "new ratio adopted", startNew - tChg, 200);
  endtask

  task automatic testSkew();
    longint tEnd, lastE, hi, lo;
    int n16;
    setSel(2'b00);
    waitCycles(60);
    divSel[0] = 1'b1;
    waitCycles(4);
    divSel[1] = 1'b1;
    n16 = 0;
    lastE = -1;
    tEnd = $time + 400;
    while ($time < tEnd) begin
      @(cardClk);
      if (lastE >= 0 && ($time - lastE) == 16) n16++;
      lastE = $time;
    end
    check(n16 == 0, "R4", "short intermediate code ignored", n16, 0);
    measureHL(hi, lo);
    check(hi == 8 && lo == 8, "R4", "final ratio after skewed bits", hi, 8);
  endtask

  task automatic testSwitch(logic [1:0] from, logic [1:0] to, int offset);
    longint tEnd, lastE, w, hf, ht, hi, lo;
    int bad, narrow0;
    hf = halfNs(from);
    ht = halfNs(to);
    setSel(from);
    waitCycles(50);
    #(offset);
    narrow0 = narrowCnt;
    setSel(to);
    bad = 0;
    lastE = -1;
    tEnd = $time + 480;
    while ($time < tEnd) begin
      @(cardClk);
      if (lastE >= 0) begin
        w = $time - lastE;
        if (!(w == hf || w == ht || (to == 2'b10 && w == hf + 8))) bad++;
      end
      lastE = $time;
    end
    check(bad == 0, "R5", $sformatf("phase widths %b->%b", from, to), bad, 0);
    check(narrowCnt == narrow0, "R6", $sformatf("no runt %b->%b", from, to), narrowCnt - narrow0, 0);
    measureHL(hi, lo);
    check(hi == ht && lo == ht, "R5", $sformatf("new ratio %b->%b", from, to), hi, ht);
  endtask

  initial begin
    automatic logic [1:0] codes [4] = '{2'b00, 2'b01, 2'b11, 2'b10};
    automatic int k = 0;
    testReset();
    for (int i = 0; i < 4; i++) testSteady(codes[i]);
    testSettle();
    testSkew();
    for (int a = 0; a < 4; a++) begin
      for (int b = 0; b < 4; b++) begin
        if (a != b) begin
          testSwitch(codes[a], codes[b], k % 2);
          k++;
        end
      end
    end
    check(narrowCnt == 0, "R6", "total narrow phases", narrowCnt, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #400000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule